// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block moves received frames from a byte stream into memory buffers described by a circular ring of linked descriptors. Each descriptor occupies three consecutive words of a descriptor store: a link to the next descriptor, a command/status word, and the byte address of a data buffer. Software arms a descriptor by writing the buffer capacity into the low twelve bits of the command/status word with bit 31 clear. The engine fetches the armed descriptor, writes the frame bytes into the buffer one per cycle, then writes back a completion word and follows the link.

A completed descriptor has bit 31 set, so the engine never reuses it until software re-arms it. When the engine reaches a descriptor that is still marked complete, it stops and discards traffic until software issues a receive-enable command. Separate command strobes enable, disable and clear the receive side, and the ring pointer is reloaded from a base address input on a clear. Frames that start while the engine cannot accept them are discarded whole, never partially stored.

Top module: `rx_ring_writer`

## Requirements
- R1: After reset the engine is idle: no descriptor read, descriptor write or memory write takes place until an enable command arrives.
- R2: The enable strobe (command bit 2) starts the engine, which first reads the current descriptor; while idle, incoming frames are discarded and nothing is written.
- R3: A descriptor at word address D holds the link at D+0, the command/status word at D+1 and the buffer byte address at D+2; it is free for the engine when bit 31 of the command/status word is clear, and bits 11:0 then give the buffer capacity in bytes.
- R4: The bytes of an accepted frame are written in order to consecutive byte addresses starting at the descriptor's buffer address, one byte per write.
- R5: On the last byte the engine writes the command/status word with bit 31 set, bit 30 (continuation) clear and bits 11:0 equal to the number of bytes stored, frame check bytes included.
- R6: Bit 27 (good frame) is set only when the error flag was clear on the last byte and the frame fit the buffer; a frame ended with the error flag gets bit 27 clear.
- R7: A frame longer than the buffer capacity is cut at the capacity: no byte beyond it is written, bits 11:0 equal the capacity, bit 22 (too long) is set and bit 27 is clear.
- R8: After each write-back the engine follows the link; the ring closes, so the descriptor after the last one is the first one again.
- R9: If the next descriptor has bit 31 set, the engine goes idle without writing it and discards frames; an enable command re-reads that same descriptor.
- R10: The disable strobe (command bit 3) stops the engine once any frame in progress has completed; disable wins over enable when both are given together.
- R11: The clear strobe (command bit 5) puts the engine idle and reloads the current descriptor pointer from the ring base input.
- R12: A frame whose first byte arrives while the engine is not ready for it is discarded entirely, even if the engine becomes ready before the frame ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ring_base | input | ADDR_W | Word address of the first descriptor of the ring |
| rx_en_cmd | input | 1 | Receive-enable command strobe (command bit 2) |
| rx_dis_cmd | input | 1 | Receive-disable command strobe (command bit 3) |
| rx_clr_cmd | input | 1 | Receive-side clear command strobe (command bit 5) |
| in_valid | input | 1 | Byte on in_data is valid this cycle |
| in_data | input | 8 | Received frame byte |
| in_last | input | 1 | This byte ends the frame |
| in_err | input | 1 | Frame is bad; sampled with in_last |
| desc_rd_en | output | 1 | Descriptor read request; data returns the next cycle |
| desc_wr_en | output | 1 | Descriptor write request |
| desc_addr | output | ADDR_W | Descriptor word address for read or write |
| desc_rd_data | input | 32 | Descriptor read data, one cycle after desc_rd_en |
| desc_wr_data | output | 32 | Descriptor write data |
| mem_wr_en | output | 1 | Buffer byte write request |
| mem_wr_addr | output | ADDR_W | Buffer byte address |
| mem_wr_data | output | 8 | Buffer byte data |

## Verification
The bench drives an over-long frame into a small buffer and counts memory writes and a sentinel byte just past the buffer, so a design that kept writing or that reported the full frame length is caught. It lets the ring run into a descriptor that software has not re-armed, so an engine that overwrote a completed descriptor or skipped ahead to the next one shows up as a corrupted buffer or status word. It sends frames while disabled, together with an enable, and straight after an enable that is still fetching, so an engine that gave enable priority or stored the tail of a half-seen frame leaves visible writes. A clear followed by a new frame shows whether the pointer really went back to the ring base rather than staying where the ring stopped.

// File: rtl/rxr_pkg.sv
package rxr_pkg;

    // Completion word bit positions (software decodes these)
    localparam int STS_OWN   = 31;
    localparam int STS_MORE  = 30;
    localparam int STS_OK    = 27;
    localparam int STS_LONG  = 22;
    localparam int STS_LEN_W = 12;
    localparam int BYTE_W    = 8;

    // Word offsets inside one descriptor
    localparam int OFS_LINK = 0;
    localparam int OFS_STS  = 1;
    localparam int OFS_PTR  = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ISSUE_STS,
        ST_TAKE_STS,
        ST_TAKE_PTR,
        ST_TAKE_LNK,
        ST_READY,
        ST_WBACK
    } eng_state_t;

    typedef struct packed {
        logic start;
        logic stop;
        logic clear;
    } rx_cmd_t;

    typedef struct packed {
        logic [STS_LEN_W-1:0] len;
        logic                 overflow;
        logic                 bad;
    } rx_result_t;

    function automatic logic [31:0] pack_status(input rx_result_t r);
        logic [31:0] w;
        w                  = '0;
        w[STS_OWN]         = 1'b1;
        w[STS_MORE]        = 1'b0;
        w[STS_OK]          = !r.overflow && !r.bad;
        w[STS_LONG]        = r.overflow;
        w[STS_LEN_W-1:0]   = r.len;
        return w;
    endfunction

endpackage

// File: rtl/rxr_cmd_arbiter.sv
module rxr_cmd_arbiter
    import rxr_pkg::*;
(
    input  logic    en_strobe,
    input  logic    dis_strobe,
    input  logic    clr_strobe,
    output rx_cmd_t cmd
);
    // Clear dominates everything; stop dominates start.
    always_comb begin
        cmd.clear = clr_strobe;
        cmd.stop  = dis_strobe && !clr_strobe;
        cmd.start = en_strobe && !dis_strobe && !clr_strobe;
    end
endmodule

// File: rtl/rxr_byte_path.sv
module rxr_byte_path
    import rxr_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clear,
    input  logic                 take,
    input  logic [BYTE_W-1:0]    byte_in,
    input  logic [ADDR_W-1:0]    buf_base,
    input  logic [STS_LEN_W-1:0] buf_size,
    output logic                 wr_en,
    output logic [ADDR_W-1:0]    wr_addr,
    output logic [BYTE_W-1:0]    wr_data,
    output logic [STS_LEN_W-1:0] stored_len,
    output logic                 overflow
);
    logic room;

    always_comb room = stored_len < buf_size;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            wr_en      <= 1'b0;
            wr_addr    <= '0;
            wr_data    <= '0;
            stored_len <= '0;
            overflow   <= 1'b0;
        end else begin
            wr_en <= 1'b0;
            if (take) begin
                if (room) begin
                    wr_en      <= 1'b1;
                    wr_addr    <= buf_base + ADDR_W'(stored_len);
                    wr_data    <= byte_in;
                    stored_len <= stored_len + 1'b1;
                end else begin
                    overflow   <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/rxr_status_pack.sv
module rxr_status_pack
    import rxr_pkg::*;
(
    input  logic [STS_LEN_W-1:0] stored_len,
    input  logic                 overflow,
    input  logic                 bad,
    output logic [31:0]          status_word
);
    rx_result_t res;

    always_comb begin
        res.len      = stored_len;
        res.overflow = overflow;
        res.bad      = bad;
        status_word  = pack_status(res);
    end
endmodule

// File: rtl/rx_ring_writer.sv
module rx_ring_writer
    import rxr_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [ADDR_W-1:0]    ring_base,
    input  logic                 rx_en_cmd,
    input  logic                 rx_dis_cmd,
    input  logic                 rx_clr_cmd,
    input  logic                 in_valid,
    input  logic [BYTE_W-1:0]    in_data,
    input  logic                 in_last,
    input  logic                 in_err,
    output logic                 desc_rd_en,
    output logic                 desc_wr_en,
    output logic [ADDR_W-1:0]    desc_addr,
    input  logic [31:0]          desc_rd_data,
    output logic [31:0]          desc_wr_data,
    output logic                 mem_wr_en,
    output logic [ADDR_W-1:0]    mem_wr_addr,
    output logic [BYTE_W-1:0]    mem_wr_data
);
    localparam logic [ADDR_W-1:0] OFF_LINK = ADDR_W'(OFS_LINK);
    localparam logic [ADDR_W-1:0] OFF_STS  = ADDR_W'(OFS_STS);
    localparam logic [ADDR_W-1:0] OFF_PTR  = ADDR_W'(OFS_PTR);

    eng_state_t           state_q;
    logic [ADDR_W-1:0]    cur_q;
    logic [ADDR_W-1:0]    link_q;
    logic [ADDR_W-1:0]    buf_q;
    logic [STS_LEN_W-1:0] size_q;
    logic                 stop_pend_q;
    logic                 in_frame_q;
    logic                 dropping_q;
    logic                 bad_q;

    rx_cmd_t              cmd;
    logic                 clear_now;
    logic                 take;
    logic                 path_clear;
    logic [STS_LEN_W-1:0] stored_len;
    logic                 overflow;
    logic [31:0]          status_word;

    rxr_cmd_arbiter u_cmd (
        .en_strobe (rx_en_cmd),
        .dis_strobe(rx_dis_cmd),
        .clr_strobe(rx_clr_cmd),
        .cmd       (cmd)
    );

    always_comb clear_now = cmd.clear;

    // A byte is accepted only in the ready state, outside a discarded frame,
    // and not when a stop is pending before a frame has begun.
    always_comb take = in_valid && (state_q == ST_READY) && !dropping_q
                       && (in_frame_q || !stop_pend_q);

    always_comb path_clear = (state_q == ST_WBACK) || cmd.clear;

    rxr_byte_path #(.ADDR_W(ADDR_W)) u_path (
        .clk       (clk),
        .rst       (rst),
        .clear     (path_clear),
        .take      (take),
        .byte_in   (in_data),
        .buf_base  (buf_q),
        .buf_size  (size_q),
        .wr_en     (mem_wr_en),
        .wr_addr   (mem_wr_addr),
        .wr_data   (mem_wr_data),
        .stored_len(stored_len),
        .overflow  (overflow)
    );

    rxr_status_pack u_pack (
        .stored_len (stored_len),
        .overflow   (overflow),
        .bad        (bad_q),
        .status_word(status_word)
    );

    // Descriptor port requests
    always_comb begin
        desc_rd_en   = 1'b0;
        desc_wr_en   = 1'b0;
        desc_addr    = cur_q + OFF_STS;
        desc_wr_data = status_word;
        unique case (state_q)
            ST_ISSUE_STS: begin
                desc_rd_en = 1'b1;
                desc_addr  = cur_q + OFF_STS;
            end
            ST_TAKE_STS: begin
                if (!desc_rd_data[STS_OWN]) begin
                    desc_rd_en = 1'b1;
                    desc_addr  = cur_q + OFF_PTR;
                end
            end
            ST_TAKE_PTR: begin
                desc_rd_en = 1'b1;
                desc_addr  = cur_q + OFF_LINK;
            end
            ST_WBACK: begin
                desc_wr_en = 1'b1;
                desc_addr  = cur_q + OFF_STS;
            end
            default: ;
        endcase
    end

    // Engine sequence
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            cur_q       <= ring_base;
            link_q      <= '0;
            buf_q       <= '0;
            size_q      <= '0;
            stop_pend_q <= 1'b0;
            in_frame_q  <= 1'b0;
            dropping_q  <= 1'b0;
            bad_q       <= 1'b0;
        end else if (cmd.clear) begin
            state_q     <= ST_IDLE;
            cur_q       <= ring_base;
            stop_pend_q <= 1'b0;
            in_frame_q  <= 1'b0;
            bad_q       <= 1'b0;
            dropping_q  <= (in_frame_q || dropping_q || in_valid) && !(in_valid && in_last);
        end else begin
            if (cmd.stop) begin
                stop_pend_q <= 1'b1;
            end else if (cmd.start) begin
                stop_pend_q <= 1'b0;
            end

            if (in_valid && !take) begin
                dropping_q <= !in_last;
            end

            unique case (state_q)
                ST_IDLE: begin
                    if (cmd.start) begin
                        state_q <= ST_ISSUE_STS;
                    end
                end
                ST_ISSUE_STS: begin
                    state_q <= ST_TAKE_STS;
                end
                ST_TAKE_STS: begin
                    if (desc_rd_data[STS_OWN]) begin
                        state_q <= ST_IDLE;
                    end else begin
                        size_q  <= desc_rd_data[STS_LEN_W-1:0];
                        state_q <= ST_TAKE_PTR;
                    end
                end
                ST_TAKE_PTR: begin
                    buf_q   <= desc_rd_data[ADDR_W-1:0];
                    state_q <= ST_TAKE_LNK;
                end
                ST_TAKE_LNK: begin
                    link_q  <= desc_rd_data[ADDR_W-1:0];
                    state_q <= (stop_pend_q || cmd.stop) ? ST_IDLE : ST_READY;
                end
                ST_READY: begin
                    if (take) begin
                        in_frame_q <= 1'b1;
                        if (in_last) begin
                            bad_q   <= in_err;
                            state_q <= ST_WBACK;
                        end
                    end else if (stop_pend_q && !in_frame_q) begin
                        state_q <= ST_IDLE;
                    end
                end
                ST_WBACK: begin
                    cur_q      <= link_q;
                    in_frame_q <= 1'b0;
                    bad_q      <= 1'b0;
                    state_q    <= (stop_pend_q || cmd.stop) ? ST_IDLE : ST_ISSUE_STS;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/rxr_checker.sv
module rxr_checker
    import rxr_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input logic                 clk,
    input logic                 rst,
    input eng_state_t           state_q,
    input logic [ADDR_W-1:0]    cur_q,
    input logic [ADDR_W-1:0]    ring_base,
    input logic                 clear_now,
    input logic                 desc_rd_en,
    input logic                 desc_wr_en,
    input logic [31:0]          desc_rd_data,
    input logic [31:0]          desc_wr_data,
    input logic [STS_LEN_W-1:0] size_q,
    input logic                 mem_wr_en
);
    // R3
    port_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(desc_rd_en && desc_wr_en));

    // R5
    own_set_chk: assert property (@(posedge clk) disable iff (rst)
        desc_wr_en |-> (desc_wr_data[STS_OWN] && !desc_wr_data[STS_MORE]));

    // R6
    ok_clean_chk: assert property (@(posedge clk) disable iff (rst)
        (desc_wr_en && desc_wr_data[STS_OK]) |-> !desc_wr_data[STS_LONG]);

    // R7
    len_cap_chk: assert property (@(posedge clk) disable iff (rst)
        desc_wr_en |-> (desc_wr_data[STS_LEN_W-1:0] <= size_q));

    // R4
    write_source_chk: assert property (@(posedge clk) disable iff (rst)
        mem_wr_en |-> ($past(state_q) == ST_READY));

    // R9
    stall_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_TAKE_STS && desc_rd_data[STS_OWN] && !clear_now) |=> (state_q == ST_IDLE));

    // R11
    clear_chk: assert property (@(posedge clk) disable iff (rst)
        clear_now |=> (state_q == ST_IDLE && cur_q == $past(ring_base)));
endmodule

bind rx_ring_writer rxr_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .state_q     (state_q),
    .cur_q       (cur_q),
    .ring_base   (ring_base),
    .clear_now   (clear_now),
    .desc_rd_en  (desc_rd_en),
    .desc_wr_en  (desc_wr_en),
    .desc_rd_data(desc_rd_data),
    .desc_wr_data(desc_wr_data),
    .size_q      (size_q),
    .mem_wr_en   (mem_wr_en)
);

// File: tb/rx_ring_writer_test.sv
`timescale 1ns/1ps
module rx_ring_writer_test;
    localparam int ADDR_W = 32;
    localparam int RING   = 4;
    localparam int BASE   = 16;
    localparam int BUF0   = 256;
    localparam int BUFSP  = 1536;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [ADDR_W-1:0] ring_base = ADDR_W'(BASE);
    logic              rx_en_cmd = 0, rx_dis_cmd = 0, rx_clr_cmd = 0;
    logic              in_valid = 0, in_last = 0, in_err = 0;
    logic [7:0]        in_data = 0;
    logic              desc_rd_en, desc_wr_en, mem_wr_en;
    logic [ADDR_W-1:0] desc_addr, mem_wr_addr;
    logic [31:0]       desc_rd_data = 0, desc_wr_data;
    logic [7:0]        mem_wr_data;

    logic [31:0] dmem [64];
    logic [7:0]  bmem [8192];
    int          wr_count = 0;
    int          checks = 0, errors = 0;

    always #2.5 clk = ~clk;

    rx_ring_writer #(.ADDR_W(ADDR_W)) uut (
        .clk(clk), .rst(rst), .ring_base(ring_base),
        .rx_en_cmd(rx_en_cmd), .rx_dis_cmd(rx_dis_cmd), .rx_clr_cmd(rx_clr_cmd),
        .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_err(in_err),
        .desc_rd_en(desc_rd_en), .desc_wr_en(desc_wr_en), .desc_addr(desc_addr),
        .desc_rd_data(desc_rd_data), .desc_wr_data(desc_wr_data),
        .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data)
    );

    // Memory models
    always @(posedge clk) begin
        if (desc_rd_en) desc_rd_data <= dmem[desc_addr[5:0]];
        if (desc_wr_en) dmem[desc_addr[5:0]] <= desc_wr_data;
        if (mem_wr_en) begin
            bmem[mem_wr_addr[12:0]] <= mem_wr_data;
            wr_count <= wr_count + 1;
        end
    end

    function automatic int d_at(int i);
        return BASE + 4 * i;
    endfunction

    function automatic int b_at(int i);
        return BUF0 + BUFSP * i;
    endfunction

    task automatic check32(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic check_buf(string tag, int base, int len, logic [7:0] seed);
        int bad = 0;
        for (int k = 0; k < len; k++)
            if (bmem[(base + k) & 8191] !== 8'(seed + k)) bad++;
        check32(tag, bad, 0);
    endtask

    task automatic arm(int i, int size);
        dmem[d_at(i) + 1] = 32'(size);
    endtask

    task automatic do_cmd(logic e, logic d, logic c);
        rx_en_cmd = e; rx_dis_cmd = d; rx_clr_cmd = c;
        @(negedge clk);
        rx_en_cmd = 0; rx_dis_cmd = 0; rx_clr_cmd = 0;
    endtask

    task automatic send_frame(int len, logic [7:0] seed, logic err);
        for (int k = 0; k < len; k++) begin
            in_valid = 1; in_data = 8'(seed + k);
            in_last = (k == len - 1); in_err = err && (k == len - 1);
            @(negedge clk);
        end
        in_valid = 0; in_last = 0; in_err = 0;
    endtask

    task automatic settle(int n);
        repeat (n) @(negedge clk);
    endtask

    // R1, R2: quiet after reset, frames discarded while idle
    task automatic t_reset_idle();
        int quiet = 0;
        int w0;
        for (int k = 0; k < 5; k++) begin
            if (desc_rd_en || desc_wr_en || mem_wr_en) quiet++;
            @(negedge clk);
        end
        check32("R1 no port activity after reset", quiet, 0);
        w0 = wr_count;
        send_frame(10, 8'h50, 0);
        settle(4);
        check32("R2 idle engine writes no bytes", wr_count - w0, 0);
        check32("R2 idle engine leaves descriptor 0", dmem[d_at(0) + 1], 32'd1536);
    endtask

    // R2, R3, R4, R5: first good frame
    task automatic t_good_frame();
        do_cmd(1, 0, 0);
        settle(10);
        send_frame(60, 8'h10, 0);
        settle(6);
        check32("R5 status of 60-byte good frame", dmem[d_at(0) + 1], 32'h8800_003C);
        check_buf("R4 buffer 0 contents", b_at(0), 60, 8'h10);
    endtask

    // R6: error flag on last byte
    task automatic t_error_frame();
        send_frame(20, 8'h30, 1);
        settle(6);
        check32("R6 status of errored frame", dmem[d_at(1) + 1], 32'h8000_0014);
        check_buf("R4 buffer 1 contents", b_at(1), 20, 8'h30);
    endtask

    // R7: descriptor 2 armed with 32 bytes, frame of 40
    task automatic t_too_long();
        int w0 = wr_count;
        send_frame(40, 8'h70, 0);
        settle(6);
        check32("R7 status of cut frame", dmem[d_at(2) + 1], 32'h8040_0020);
        check32("R7 byte writes stop at capacity", wr_count - w0, 32);
        check32("R7 byte past capacity untouched", {24'h0, bmem[b_at(2) + 32]}, 32'h0000_00EE);
        check_buf("R4 buffer 2 stored part", b_at(2), 32, 8'h70);
    endtask

    // R8, R9: last descriptor, stall on completed descriptor, wrap on resume
    task automatic t_wrap_stall();
        int w0;
        send_frame(64, 8'h90, 0);
        settle(6);
        check32("R5 status of descriptor 3", dmem[d_at(3) + 1], 32'h8800_0040);
        w0 = wr_count;
        send_frame(16, 8'hC0, 0);
        settle(6);
        check32("R9 stalled engine writes no bytes", wr_count - w0, 0);
        check32("R9 completed descriptor 0 not rewritten", dmem[d_at(0) + 1], 32'h8800_003C);
        arm(0, 1536);
        do_cmd(1, 0, 0);
        settle(10);
        send_frame(30, 8'hA0, 0);
        settle(6);
        check32("R8 ring wraps to descriptor 0", dmem[d_at(0) + 1], 32'h8800_001E);
        check_buf("R8 buffer 0 reused", b_at(0), 30, 8'hA0);
    endtask

    // R10: disable together with enable stops the engine
    task automatic t_disable();
        int w0;
        arm(1, 1536);
        do_cmd(1, 0, 0);
        settle(10);
        do_cmd(1, 1, 0);
        settle(3);
        w0 = wr_count;
        send_frame(25, 8'h44, 0);
        settle(6);
        check32("R10 disabled engine writes no bytes", wr_count - w0, 0);
        check32("R10 descriptor 1 stays armed", dmem[d_at(1) + 1], 32'd1536);
    endtask

    // R11, R12: clear returns to ring base; frame during fetch dropped
    task automatic t_clear();
        int w0;
        do_cmd(0, 0, 1);
        arm(0, 1536);
        do_cmd(1, 0, 0);
        w0 = wr_count;
        send_frame(12, 8'h22, 0);
        settle(6);
        check32("R12 frame begun during fetch writes nothing", wr_count - w0, 0);
        check32("R12 descriptor 0 untouched by dropped frame", dmem[d_at(0) + 1], 32'd1536);
        send_frame(16, 8'hD0, 0);
        settle(6);
        check32("R11 frame after clear lands in descriptor 0", dmem[d_at(0) + 1], 32'h8800_0010);
        check32("R11 descriptor 1 untouched", dmem[d_at(1) + 1], 32'd1536);
        check_buf("R11 buffer 0 contents", b_at(0), 16, 8'hD0);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) dmem[i] = 32'h0;
        for (int i = 0; i < 8192; i++) bmem[i] = 8'hEE;
        for (int i = 0; i < RING; i++) begin
            dmem[d_at(i)]     = 32'(d_at((i + 1) % RING));
            dmem[d_at(i) + 1] = 32'd1536;
            dmem[d_at(i) + 2] = 32'(b_at(i));
        end
        arm(2, 32);
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset_idle();
        t_good_frame();
        t_error_frame();
        t_too_long();
        t_wrap_stall();
        t_disable();
        t_clear();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule